// File: doc/BRIEF.md
# Boot Command Frame Transmitter for MultiMediaCard Start-Up

This block sends one 48-bit MultiMediaCard command frame, most significant bit first, on a single serial command line. A host raises a one-cycle start request together with a 3-bit selector that picks one of six fixed start-up commands. The block captures the selection and builds a 40-bit header: a start bit, a transmission bit, the 6-bit command index and the 32-bit argument for that command. The block shifts the header out one bit per clock. While the header goes out, a serial CRC7 is computed over it. The seven CRC bits follow the header, and a closing '1' ends the frame.

The output-enable is high for exactly the 48 frame cycles. Outside a frame the line rests at '1'. A single-cycle done pulse marks the end of each frame. The block does not sequence several commands, does not listen for card responses and does not touch the data lines. A controller above it issues each command in turn.

Top module: `mmc_boot_cmd_tx`

## Requirements
- R1: After reset, and in every cycle where `cmd_oe_o` is low, `cmd_o` is 1, and `done_o` is 0 except in its one pulse cycle.
- R2: When a start request is sampled at clock edge k, `cmd_oe_o` is still low after edge k. It is high for exactly 48 consecutive cycles starting after edge k+1, and low after edge k+49.
- R3: Frame bit 0 (the first bit on the line) is 0 and frame bit 1 is 1.
- R4: Frame bits 2..7 carry the 6-bit command index, MSB first. Selector codes 0,1,2,3,4,5 give indices 0,1,2,3,7,11. Codes 6 and 7 behave exactly like code 0.
- R5: Frame bits 8..39 carry the 32-bit argument, MSB first. The argument is 0x80FF8000 for index 1 and 0x00010000 (card address 1 in bits 31:16) for indices 3 and 7. It is 0 for indices 0, 2 and 11.
- R6: Frame bits 40..46 carry the CRC7 (polynomial x^7+x^3+1, register starting at zero) of frame bits 0..39, MSB first. Bits 40..47 form the byte 0x95 for index 0, 0x4D for index 2, 0x7F for index 3, 0xDD for index 7 and 0x77 for index 11.
- R7: Frame bit 47 is 1.
- R8: `done_o` is high for exactly one cycle, the cycle right after the last frame bit, when `cmd_oe_o` has just dropped.
- R9: A start request sampled while a frame is pending or on the line (from the accepting edge up to and including the cycle of bit 47) is ignored. Changes to `sel_i` in that window do not alter the frame in progress.
- R10: A start request held high in the `done_o` cycle is accepted, and the next frame begins two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send one frame |
| sel_i | input | 3 | Command selector, captured when start is accepted |
| cmd_o | output | 1 | Serial command line, registered |
| cmd_oe_o | output | 1 | Drive enable for the command line, registered |
| done_o | output | 1 | One-cycle end-of-frame pulse, registered |

## Verification
The bench captures all six commands and the two aliased selector codes bit by bit. It checks the CRC byte against fixed known values. A CRC register that starts from a wrong value, misses the start bit, or updates one cycle too long or too short would corrupt those bytes. The bench pokes start and changes the selector mid-frame and during the stop-bit cycle. A design that restarts early would cut the frame short or send a second, unrequested frame. The bench also re-arms in the done cycle. An off-by-one in the idle gating would either lose that request or let the stop-bit-cycle request through.

// File: rtl/mmcb_pkg.sv
package mmcb_pkg;

  localparam int CMD_IDX_W = 6;
  localparam int CMD_ARG_W = 32;
  localparam int SEL_W     = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_GO_IDLE   = 3'd0,
    SEL_OP_COND   = 3'd1,
    SEL_READ_ID   = 3'd2,
    SEL_GIVE_ADDR = 3'd3,
    SEL_PICK_CARD = 3'd4,
    SEL_STREAM_RD = 3'd5
  } boot_sel_e;

  typedef enum logic [1:0] {
    PH_HEADER = 2'd0,
    PH_CHECK  = 2'd1,
    PH_CLOSE  = 2'd2
  } frame_phase_e;

  typedef struct packed {
    logic [CMD_IDX_W-1:0] idx;
    logic [CMD_ARG_W-1:0] arg;
  } boot_cmd_t;

endpackage

// File: rtl/mmcb_cmd_table.sv
module mmcb_cmd_table
  import mmcb_pkg::*;
#(
  parameter logic [CMD_ARG_W-1:0] OP_COND_ARG = 32'h80FF_8000,
  parameter logic [15:0]          CARD_ADDR   = 16'h0001
) (
  input  logic [SEL_W-1:0] sel,
  output boot_cmd_t        entry
);

  localparam logic [CMD_ARG_W-1:0] ADDR_ARG = {CARD_ADDR, {(CMD_ARG_W-16){1'b0}}};

  always_comb begin
    entry = '0;
    case (sel)
      SEL_OP_COND: begin
        entry.idx = CMD_IDX_W'(1);
        entry.arg = OP_COND_ARG;
      end
      SEL_READ_ID: begin
        entry.idx = CMD_IDX_W'(2);
        entry.arg = '0;
      end
      SEL_GIVE_ADDR: begin
        entry.idx = CMD_IDX_W'(3);
        entry.arg = ADDR_ARG;
      end
      SEL_PICK_CARD: begin
        entry.idx = CMD_IDX_W'(7);
        entry.arg = ADDR_ARG;
      end
      SEL_STREAM_RD: begin
        entry.idx = CMD_IDX_W'(11);
        entry.arg = '0;
      end
      default: begin
        entry.idx = '0;
        entry.arg = '0;
      end
    endcase
  end

endmodule

// File: rtl/mmcb_crc_serial.sv
module mmcb_crc_serial #(
  parameter int             W    = 7,
  parameter logic [W-1:0]   POLY = 7'h09
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic upd,
  input  logic shift,
  input  logic din,
  output logic msb
);

  logic [W-1:0] crc_q;
  logic         fb;

  assign fb  = din ^ crc_q[W-1];
  assign msb = crc_q[W-1];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q <= '0;
    end else if (upd) begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end else if (shift) begin
      crc_q <= {crc_q[W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/mmcb_frame_seq.sv
module mmcb_frame_seq
  import mmcb_pkg::*;
#(
  parameter int HDR_BITS   = 40,
  parameter int FRAME_BITS = 48,
  localparam int CNT_W     = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             line_busy,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output frame_phase_e     phase
);

  logic [CNT_W-1:0] cnt_q;

  assign accept = start && !busy && !line_busy;
  assign last   = busy && (cnt_q == CNT_W'(FRAME_BITS-1));

  always_comb begin
    if (cnt_q < CNT_W'(HDR_BITS))          phase = PH_HEADER;
    else if (cnt_q < CNT_W'(FRAME_BITS-1)) phase = PH_CHECK;
    else                                   phase = PH_CLOSE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (last) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mmc_boot_cmd_tx.sv
module mmc_boot_cmd_tx
  import mmcb_pkg::*;
#(
  parameter int                   CRC_W       = 7,
  parameter logic [CRC_W-1:0]     CRC_POLY    = 7'h09,
  parameter logic [CMD_ARG_W-1:0] OP_COND_ARG = 32'h80FF_8000,
  parameter logic [15:0]          CARD_ADDR   = 16'h0001,
  localparam int HDR_BITS   = 2 + CMD_IDX_W + CMD_ARG_W,
  localparam int FRAME_BITS = HDR_BITS + CRC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cmd_o,
  output logic             cmd_oe_o,
  output logic             done_o
);

  boot_cmd_t         entry;
  logic              accept;
  logic              busy;
  logic              last;
  frame_phase_e      phase;
  logic [HDR_BITS-1:0] hdr_q;
  logic              crc_msb;
  logic              tx_bit;
  logic              last_q;

  mmcb_cmd_table #(
    .OP_COND_ARG (OP_COND_ARG),
    .CARD_ADDR   (CARD_ADDR)
  ) u_table (
    .sel   (sel_i),
    .entry (entry)
  );

  mmcb_frame_seq #(
    .HDR_BITS   (HDR_BITS),
    .FRAME_BITS (FRAME_BITS)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .line_busy (cmd_oe_o),
    .accept    (accept),
    .busy      (busy),
    .last      (last),
    .phase     (phase)
  );

  // header shift register: start '0', transmission '1', index, argument
  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q <= '0;
    end else if (accept) begin
      hdr_q <= {1'b0, 1'b1, entry.idx, entry.arg};
    end else if (busy) begin
      hdr_q <= {hdr_q[HDR_BITS-2:0], 1'b0};
    end
  end

  mmcb_crc_serial #(
    .W    (CRC_W),
    .POLY (CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .upd   (busy && (phase == PH_HEADER)),
    .shift (busy && (phase == PH_CHECK)),
    .din   (hdr_q[HDR_BITS-1]),
    .msb   (crc_msb)
  );

  always_comb begin
    case (phase)
      PH_HEADER: tx_bit = hdr_q[HDR_BITS-1];
      PH_CHECK:  tx_bit = crc_msb;
      default:   tx_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o    <= 1'b1;
      cmd_oe_o <= 1'b0;
      last_q   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      cmd_o    <= busy ? tx_bit : 1'b1;
      cmd_oe_o <= busy;
      last_q   <= last;
      done_o   <= last_q;
    end
  end

endmodule

// File: rtl/mmcb_tx_chk.sv
module mmcb_tx_chk #(
  parameter int FRAME_BITS = 48,
  localparam int RUN_W     = $clog2(FRAME_BITS + 1) + 1
) (
  input logic clk,
  input logic rst,
  input logic cmd_o,
  input logic cmd_oe_o,
  input logic done_o
);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)           run_q <= '0;
    else if (cmd_oe_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !cmd_oe_o |-> cmd_o); // R1
  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_oe_o) |-> ($past(run_q) == RUN_W'(FRAME_BITS-1))); // R2
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    cmd_oe_o |-> (run_q < RUN_W'(FRAME_BITS))); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_oe_o) |-> !cmd_o); // R3
  AST_TX_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cmd_oe_o && run_q == RUN_W'(1)) |-> cmd_o); // R3
  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (cmd_oe_o && run_q == RUN_W'(FRAME_BITS-1)) |-> cmd_o); // R7
  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!cmd_oe_o && $past(cmd_oe_o))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

endmodule

bind mmc_boot_cmd_tx mmcb_tx_chk #(.FRAME_BITS(FRAME_BITS)) u_tx_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_o    (cmd_o),
  .cmd_oe_o (cmd_oe_o),
  .done_o   (done_o)
);

// File: tb/test_mmc_boot_cmd_tx.sv
`timescale 1ns/1ps
module test_mmc_boot_cmd_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       cmd_o;
  logic       cmd_oe_o;
  logic       done_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmc_boot_cmd_tx i_mmc_boot_cmd_tx (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .sel_i    (sel_i),
    .cmd_o    (cmd_o),
    .cmd_oe_o (cmd_oe_o),
    .done_o   (done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_idx(input logic [2:0] s);
    case (s)
      3'd1: return 6'd1;
      3'd2: return 6'd2;
      3'd3: return 6'd3;
      3'd4: return 6'd7;
      3'd5: return 6'd11;
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_arg(input logic [2:0] s);
    case (s)
      3'd1: return 32'h80FF8000;
      3'd3, 3'd4: return 32'h00010000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [6:0] exp_crc(input logic [39:0] h);
    logic [6:0] c = 7'h0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = h[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  // drive start for one edge; returns at the negedge after the accepting edge
  task automatic launch(input logic [2:0] s);
    start_i = 1'b1;
    sel_i   = s;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // capture a frame; caller is at the negedge right after the accepting edge
  task automatic capture(input logic [2:0] s, input int poke_at,
                         input logic [2:0] poke_sel, input bit rearm,
                         input logic [2:0] rearm_sel, output logic [47:0] got);
    int oe_bad = 0;
    logic [39:0] hdr;
    logic [47:0] exp;
    chk(cmd_oe_o == 1'b0, "R2", "oe low right after accept", cmd_oe_o, 0);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (cmd_oe_o !== 1'b1) oe_bad++;
      got[47-i] = cmd_o;
      if (i == poke_at) begin
        start_i = 1'b1;
        sel_i   = poke_sel;
      end
      if (i == poke_at + 1) start_i = 1'b0;
    end
    chk(oe_bad == 0, "R2", "oe high for 48 cycles", oe_bad, 0);
    @(negedge clk);
    if (poke_at == 47) start_i = 1'b0;
    chk(cmd_oe_o == 1'b0 && done_o == 1'b1, "R8", "done after frame",
        {cmd_oe_o, done_o}, 2'b01);
    if (rearm) begin
      start_i = 1'b1;
      sel_i   = rearm_sel;
      @(negedge clk);
      start_i = 1'b0;
      chk(done_o == 1'b0, "R8", "done one cycle", done_o, 0);
    end else begin
      @(negedge clk);
      chk(done_o == 1'b0 && cmd_o == 1'b1, "R1", "idle after done",
          {done_o, cmd_o}, 2'b01);
    end
    hdr = {1'b0, 1'b1, exp_idx(s), exp_arg(s)};
    exp = {hdr, exp_crc(hdr), 1'b1};
    chk(got[47:46] == 2'b01, "R3", "start and transmission bits", got[47:46], 2'b01);
    chk(got[45:40] == exp_idx(s), "R4", "command index", got[45:40], exp_idx(s));
    chk(got[39:8] == exp_arg(s), "R5", "argument", got[39:8], exp_arg(s));
    chk(got[7:1] == exp[7:1], "R6", "crc7", got[7:1], exp[7:1]);
    chk(got[0] == 1'b1, "R7", "stop bit", got[0], 1);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_oe_o !== 1'b0 || cmd_o !== 1'b1) bad++;
    end
    chk(bad == 0, req, "no extra frame", bad, 0);
  endtask

  task automatic t_reset();
    chk(cmd_o == 1'b1 && cmd_oe_o == 1'b0 && done_o == 1'b0, "R1",
        "reset state", {cmd_o, cmd_oe_o, done_o}, 3'b100);
  endtask

  task automatic t_known_byte(input logic [2:0] s, input logic [7:0] b);
    logic [47:0] got;
    launch(s);
    capture(s, -5, 3'd0, 1'b0, 3'd0, got);
    chk(got[7:0] == b, "R6", "closing byte", got[7:0], b);
  endtask

  task automatic t_op_cond();
    logic [47:0] got;
    launch(3'd1);
    capture(3'd1, -5, 3'd0, 1'b0, 3'd0, got);
    chk(got[39:8] == 32'h80FF8000, "R5", "op-cond argument", got[39:8], 32'h80FF8000);
  endtask

  task automatic t_alias(input logic [2:0] s);
    logic [47:0] got;
    launch(s);
    capture(s, -5, 3'd0, 1'b0, 3'd0, got);
    chk(got[7:0] == 8'h95, "R4", "alias code acts as index 0", got[7:0], 8'h95);
  endtask

  task automatic t_midframe_poke();
    logic [47:0] got;
    launch(3'd3);
    capture(3'd3, 10, 3'd5, 1'b0, 3'd0, got);
    chk(got[7:0] == 8'h7F, "R9", "frame unchanged by poke", got[7:0], 8'h7F);
    expect_quiet(6, "R9");
  endtask

  task automatic t_stopbit_poke();
    logic [47:0] got;
    launch(3'd2);
    capture(3'd2, 47, 3'd4, 1'b0, 3'd0, got);
    expect_quiet(6, "R9");
  endtask

  task automatic t_rearm();
    logic [47:0] got;
    launch(3'd4);
    capture(3'd4, -5, 3'd0, 1'b1, 3'd5, got);
    capture(3'd5, -5, 3'd0, 1'b0, 3'd0, got);
    chk(got[7:0] == 8'h77, "R10", "re-armed frame", got[7:0], 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_known_byte(3'd0, 8'h95);
    t_op_cond();
    t_known_byte(3'd2, 8'h4D);
    t_known_byte(3'd3, 8'h7F);
    t_known_byte(3'd4, 8'hDD);
    t_known_byte(3'd5, 8'h77);
    t_alias(3'd6);
    t_alias(3'd7);
    t_midframe_poke();
    t_stopbit_poke();
    t_rearm();
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule